// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block tracks a programmable sequence of comparator events and raises a trigger once the sequence is complete. It has three working states (State1, State2, State3) and a Final state. Three match pulses come from comparator channels 0, 1 and 2. Each working state has its own 4-bit route select value. That value chooses which match channels move the sequencer and where each one sends it. When several channels match in the same cycle, a move to Final wins. Otherwise the lowest-numbered channel that has a defined move wins.

Software drives the block through a small register port with a 2-bit address:
- **Address 0, control.** On write, bit 7 arms and bit 6 disarms; bits 1:0 are the bank field. On read, bit 7 is armed, bit 6 is trigger and bits 1:0 are the bank field.
- **Address 1, select window.** It exposes the route select value chosen by the bank field.
- **Address 2, status.** It reads the state code in bits 2:0 and the trigger in bit 3.

Arming starts the sequence in State1. Reaching Final sets a sticky trigger and drops the armed flag. The route select values are locked for as long as the sequencer is armed.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset the state code is 0 (idle), armed and trigger are 0, and all three route select values read 0.
- R2: A control write with bit 7 set puts the sequencer in State1 (code 1), sets armed and clears trigger; arm wins over bit 6. A control write with bit 6 set and bit 7 clear returns it to idle (code 0) and clears armed. The state codes are idle 0, State1 1, State2 2, State3 3, Final 4.
- R3: In State2 the select value routes as follows: 0000 sends ch0 to State1 and ch2 to State3; 0001 sends ch1 to State3; 0010 sends ch2 to State3; 0011 sends ch1 to State3 and ch0 to Final; 0100 sends ch1 to State1 and ch2 to State3; 1101 sends ch0 or ch2 to Final and ch1 to State2.
- R4: Select values with no defined routes (State2: 0101 to 1100, 1110, 1111) cause no transition. A match on a channel that the current value does not name leaves the state unchanged.
- R5: For matches in the same cycle, a routed move to Final takes priority. Otherwise the lowest-numbered channel with a defined route decides the move.
- R6: A match counts only when its comparator-enable bit is high in the same cycle.
- R7: Writes to the select window are ignored while armed and take effect when not armed.
- R8: The select window (address 1) maps to the State1 value when bank is 00, the State2 value when bank is 01 and the State3 value when bank is 10. Bank 11 reads zero and ignores writes.
- R9: The select window reads its upper four bits as zero, whatever was written to them.
- R10: Entering Final sets the state code to 4, sets trigger and clears armed. The trigger stays set until the next arm write.
- R11: In State1: 0000 sends ch0 to State2; 0001 sends ch1 to State2; 0010 sends ch2 to State2; 0011 sends ch1 to State3; 0100 sends ch0 to Final; 0101 sends ch1 to State2 and ch2 to Final. Other values cause no transition.
- R12: In State3: 0000 sends ch0 to State1; 0001 sends ch2 to Final; 0010 sends ch1 to State2 and ch2 to Final; 0011 sends ch0 to Final. Other values cause no transition.
- R13: While not armed, match pulses do not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from address) |
| match_i | input | 3 | Comparator match pulses, channels 0 to 2 |
| cmp_en_i | input | 3 | Comparator enables, one per channel |
| armed_o | output | 1 | Sequencer armed |
| trigger_o | output | 1 | Sticky Final-state trigger |
| state_o | output | 3 | Current state code |

## Verification
The assertions assume that only one register access happens per cycle. They also assume that matches are single-cycle pulses sampled at the rising edge, so any cycle with no register write and no enabled match must leave the state unchanged. The stimulus drives writes and match pulses on the falling edge and holds each for exactly one cycle. It always disarms before rewriting a select value, except in the test that deliberately writes while armed. Same-cycle matches are applied only as deliberate multi-bit pulses, to exercise the priority rule.

// File: rtl/dbg_seq_pkg.sv
// Shared types and route tables for the debug trigger sequencer.
// Assumes three match channels and 4-bit per-state route select values.
package dbg_seq_pkg;

    localparam int unsigned NUM_CH  = 3;
    localparam int unsigned SEL_W   = 4;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned STATE_W = 3;
    localparam int unsigned BANK_W  = 2;
    localparam int unsigned NUM_SEL = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_ONE   = 3'd1,
        ST_TWO   = 3'd2,
        ST_THREE = 3'd3,
        ST_FINAL = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic       hit;
        seq_state_e nxt;
    } route_t;

    // Build a defined route to a given state.
    function automatic route_t go(seq_state_e s);
        route_t r;
        r.hit = 1'b1;
        r.nxt = s;
        return r;
    endfunction

    // Route of one channel for the current state and select value; hit=0 means no move.
    function automatic route_t route_ch(seq_state_e st, logic [SEL_W-1:0] sel,
                                        int unsigned ch);
        route_t r;
        r.hit = 1'b0;
        r.nxt = st;
        case (st)
            ST_ONE: begin
                case (sel)
                    4'h0: if (ch == 0) r = go(ST_TWO);
                    4'h1: if (ch == 1) r = go(ST_TWO);
                    4'h2: if (ch == 2) r = go(ST_TWO);
                    4'h3: if (ch == 1) r = go(ST_THREE);
                    4'h4: if (ch == 0) r = go(ST_FINAL);
                    4'h5: begin
                        if (ch == 1) r = go(ST_TWO);
                        if (ch == 2) r = go(ST_FINAL);
                    end
                    default: r.hit = 1'b0;
                endcase
            end
            ST_TWO: begin
                case (sel)
                    4'h0: begin
                        if (ch == 0) r = go(ST_ONE);
                        if (ch == 2) r = go(ST_THREE);
                    end
                    4'h1: if (ch == 1) r = go(ST_THREE);
                    4'h2: if (ch == 2) r = go(ST_THREE);
                    4'h3: begin
                        if (ch == 1) r = go(ST_THREE);
                        if (ch == 0) r = go(ST_FINAL);
                    end
                    4'h4: begin
                        if (ch == 1) r = go(ST_ONE);
                        if (ch == 2) r = go(ST_THREE);
                    end
                    4'hD: begin
                        if (ch == 0 || ch == 2) r = go(ST_FINAL);
                        if (ch == 1) r = go(ST_TWO);
                    end
                    default: r.hit = 1'b0;
                endcase
            end
            ST_THREE: begin
                case (sel)
                    4'h0: if (ch == 0) r = go(ST_ONE);
                    4'h1: if (ch == 2) r = go(ST_FINAL);
                    4'h2: begin
                        if (ch == 1) r = go(ST_TWO);
                        if (ch == 2) r = go(ST_FINAL);
                    end
                    4'h3: if (ch == 0) r = go(ST_FINAL);
                    default: r.hit = 1'b0;
                endcase
            end
            default: r.hit = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbg_seq_regs.sv
// Register port of the sequencer: control/bank, select window, status.
// Assumes one access per cycle; reads are combinational from the address.
module dbg_seq_regs
    import dbg_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic                 armed_i,
    input  logic                 trigger_i,
    input  logic [STATE_W-1:0]   state_i,
    output logic                 arm_req_o,
    output logic                 disarm_req_o,
    output logic [SEL_W-1:0]     sel_one_o,
    output logic [SEL_W-1:0]     sel_two_o,
    output logic [SEL_W-1:0]     sel_three_o,
    output logic [DATA_W-1:0]    rdata_o
);

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_SELWIN = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;
    localparam int unsigned       PAD_SEL  = DATA_W - SEL_W;

    logic [BANK_W-1:0] bank_q;
    logic [SEL_W-1:0]  sel_q [NUM_SEL];
    logic              ctrl_wr;
    logic              sel_wr;
    logic              unused_wbits;

    assign ctrl_wr      = wr_i && (addr_i == A_CTRL);
    assign sel_wr       = wr_i && (addr_i == A_SELWIN) && !armed_i;
    assign arm_req_o    = ctrl_wr && wdata_i[7];
    assign disarm_req_o = ctrl_wr && wdata_i[6] && !wdata_i[7];
    assign unused_wbits = ^wdata_i[5:4];

    // Bank field, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)       bank_q <= '0;
        else if (ctrl_wr) bank_q <= wdata_i[BANK_W-1:0];
    end

    // One route select register per working state, locked while armed.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[g] <= '0;
            else if (sel_wr && (bank_q == BANK_W'(g)))
                sel_q[g] <= wdata_i[SEL_W-1:0];
        end
    end

    assign sel_one_o   = sel_q[0];
    assign sel_two_o   = sel_q[1];
    assign sel_three_o = sel_q[2];

    // Read data multiplexer.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL:   rdata_o = {armed_i, trigger_i, 4'b0000, bank_q};
            A_SELWIN: begin
                case (bank_q)
                    2'd0:    rdata_o = {{PAD_SEL{1'b0}}, sel_q[0]};
                    2'd1:    rdata_o = {{PAD_SEL{1'b0}}, sel_q[1]};
                    2'd2:    rdata_o = {{PAD_SEL{1'b0}}, sel_q[2]};
                    default: rdata_o = '0;
                endcase
            end
            A_STATUS: rdata_o = {4'b0000, trigger_i, state_i};
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/dbg_seq_route.sv
// Next-state resolver: per-channel route lookup, then priority pick.
// Assumes enabled match bits are already masked; Final wins, then lowest channel.
module dbg_seq_route
    import dbg_seq_pkg::*;
(
    input  seq_state_e           state_i,
    input  logic [SEL_W-1:0]     sel_one_i,
    input  logic [SEL_W-1:0]     sel_two_i,
    input  logic [SEL_W-1:0]     sel_three_i,
    input  logic [NUM_CH-1:0]    match_i,
    output logic                 step_valid_o,
    output seq_state_e           step_nxt_o
);

    logic [SEL_W-1:0] sel_cur;
    route_t           ch_route [NUM_CH];

    // Pick the select value of the current state.
    always_comb begin
        case (state_i)
            ST_ONE:   sel_cur = sel_one_i;
            ST_TWO:   sel_cur = sel_two_i;
            ST_THREE: sel_cur = sel_three_i;
            default:  sel_cur = '0;
        endcase
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_route[g] = route_ch(state_i, sel_cur, g);
    end

    // Priority: lowest routed channel first, then any Final route overrides.
    always_comb begin
        step_valid_o = 1'b0;
        step_nxt_o   = state_i;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (match_i[i] && ch_route[i].hit) begin
                step_valid_o = 1'b1;
                step_nxt_o   = ch_route[i].nxt;
            end
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (match_i[i] && ch_route[i].hit && ch_route[i].nxt == ST_FINAL)
                step_nxt_o = ST_FINAL;
        end
    end

endmodule

// File: rtl/dbg_seq_fsm.sv
// Sequencer state, armed flag and sticky trigger.
// Assumes arm/disarm requests are single-cycle; arm has precedence over all.
module dbg_seq_fsm
    import dbg_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm_req_i,
    input  logic        disarm_req_i,
    input  logic        step_valid_i,
    input  seq_state_e  step_nxt_i,
    output seq_state_e  state_o,
    output logic        armed_o,
    output logic        trigger_o
);

    seq_state_e state_q;
    logic       armed_q;
    logic       trig_q;

    // State update: arm, disarm, then routed step while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            armed_q <= 1'b0;
            trig_q  <= 1'b0;
        end else if (arm_req_i) begin
            state_q <= ST_ONE;
            armed_q <= 1'b1;
            trig_q  <= 1'b0;
        end else if (disarm_req_i) begin
            state_q <= ST_IDLE;
            armed_q <= 1'b0;
        end else if (armed_q && step_valid_i) begin
            state_q <= step_nxt_i;
            if (step_nxt_i == ST_FINAL) begin
                armed_q <= 1'b0;
                trig_q  <= 1'b1;
            end
        end
    end

    assign state_o   = state_q;
    assign armed_o   = armed_q;
    assign trigger_o = trig_q;

endmodule

// File: rtl/dbg_seq_top.sv
// Top of the debug trigger sequencer: registers, resolver and state machine.
// Assumes matches are one-cycle pulses gated by their comparator enables.
module dbg_seq_top
    import dbg_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    input  logic [NUM_CH-1:0]    match_i,
    input  logic [NUM_CH-1:0]    cmp_en_i,
    output logic                 armed_o,
    output logic                 trigger_o,
    output logic [STATE_W-1:0]   state_o
);

    logic              arm_req;
    logic              disarm_req;
    logic [SEL_W-1:0]  sel_one;
    logic [SEL_W-1:0]  sel_two;
    logic [SEL_W-1:0]  sel_three;
    logic [NUM_CH-1:0] match_eff;
    logic              step_valid;
    seq_state_e        step_nxt;
    seq_state_e        state_cur;

    assign match_eff = match_i & cmp_en_i;
    assign state_o   = state_cur;

    dbg_seq_regs i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (reg_wr_i),
        .addr_i       (reg_addr_i),
        .wdata_i      (reg_wdata_i),
        .armed_i      (armed_o),
        .trigger_i    (trigger_o),
        .state_i      (state_cur),
        .arm_req_o    (arm_req),
        .disarm_req_o (disarm_req),
        .sel_one_o    (sel_one),
        .sel_two_o    (sel_two),
        .sel_three_o  (sel_three),
        .rdata_o      (reg_rdata_o)
    );

    dbg_seq_route i_route (
        .state_i      (state_cur),
        .sel_one_i    (sel_one),
        .sel_two_i    (sel_two),
        .sel_three_i  (sel_three),
        .match_i      (match_eff),
        .step_valid_o (step_valid),
        .step_nxt_o   (step_nxt)
    );

    dbg_seq_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_req_i    (arm_req),
        .disarm_req_i (disarm_req),
        .step_valid_i (step_valid),
        .step_nxt_i   (step_nxt),
        .state_o      (state_cur),
        .armed_o      (armed_o),
        .trigger_o    (trigger_o)
    );

endmodule

// File: rtl/dbg_seq_checker.sv
// Assertion checker for dbg_seq_top, attached by bind.
// Assumes one register access per cycle and single-cycle match pulses.
module dbg_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_i,
    input logic [1:0] reg_addr_i,
    input logic [7:0] reg_wdata_i,
    input logic [2:0] match_i,
    input logic [2:0] cmp_en_i,
    input logic       armed_o,
    input logic       trigger_o,
    input logic [2:0] state_o,
    input logic [3:0] sel_one,
    input logic [3:0] sel_two,
    input logic [3:0] sel_three
);

    logic arm_wr;
    assign arm_wr = reg_wr_i && reg_addr_i == 2'd0 && reg_wdata_i[7];

    p_arm_to_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> (state_o == 3'd1 && armed_o && !trigger_o));

    p_reserved_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && state_o == 3'd2 && sel_two > 4'd4 && sel_two != 4'd13 && !reg_wr_i)
        |=> (state_o == 3'd2 && armed_o));

    p_no_match_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && (match_i & cmp_en_i) == 3'b000 && !reg_wr_i)
        |=> ($stable(state_o) && armed_o));

    p_sel_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |=> ($stable(sel_one) && $stable(sel_two) && $stable(sel_three)));

    p_final_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trigger_o) |-> (!armed_o && state_o == 3'd4));

    p_trigger_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger_o && !arm_wr) |=> trigger_o);

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && !reg_wr_i) |=> $stable(state_o));

    p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

endmodule

bind dbg_seq_top dbg_seq_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .match_i    (match_i),
    .cmp_en_i   (cmp_en_i),
    .armed_o    (armed_o),
    .trigger_o  (trigger_o),
    .state_o    (state_o),
    .sel_one    (sel_one),
    .sel_two    (sel_two),
    .sel_three  (sel_three)
);

// File: tb/test_dbg_seq_top.sv
// Directed bench for dbg_seq_top: one task per scenario, each checking itself.
module test_dbg_seq_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr_i;
    logic [1:0] reg_addr_i;
    logic [7:0] reg_wdata_i;
    logic [7:0] reg_rdata_o;
    logic [2:0] match_i;
    logic [2:0] cmp_en_i;
    logic       armed_o;
    logic       trigger_o;
    logic [2:0] state_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_seq_top i_dbg_seq_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .match_i     (match_i),
        .cmp_en_i    (cmp_en_i),
        .armed_o     (armed_o),
        .trigger_o   (trigger_o),
        .state_o     (state_o)
    );

    // Advance one clock, leaving time just after the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare and count one check.
    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One register write.
    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        tick();
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    // Combinational register read.
    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    // One-cycle match pulse with given enables.
    task automatic pulse(logic [2:0] m, logic [2:0] en);
        match_i = m; cmp_en_i = en;
        tick();
        match_i = '0; cmp_en_i = 3'b111;
    endtask

    // Disarm, choose bank and write its select value.
    task automatic set_sel(logic [1:0] bank, logic [7:0] v);
        wr(2'd0, 8'h40 | {6'b0, bank});
        wr(2'd1, v);
    endtask

    // Program State2 select, arm, and step into State2 via ch0.
    task automatic go_two(logic [3:0] s2);
        set_sel(2'd1, {4'h0, s2});
        set_sel(2'd0, 8'h00);
        wr(2'd0, 8'h80);
        pulse(3'b001, 3'b111);
    endtask

    // Program State3 select, arm, and step into State3 via ch1.
    task automatic go_three(logic [3:0] s3);
        set_sel(2'd2, {4'h0, s3});
        set_sel(2'd0, 8'h03);
        wr(2'd0, 8'h80);
        pulse(3'b010, 3'b111);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1", "state", {5'b0, state_o}, 8'd0);
        chk("R1", "armed", {7'b0, armed_o}, 8'd0);
        chk("R1", "trigger", {7'b0, trigger_o}, 8'd0);
        for (int b = 0; b < 3; b++) begin
            wr(2'd0, 8'(b));
            rd(2'd1, d);
            chk("R1", "select reset", d, 8'h00);
        end
    endtask

    task automatic t_arm();
        logic [7:0] d;
        wr(2'd0, 8'h80);
        chk("R2", "armed state", {5'b0, state_o}, 8'd1);
        chk("R2", "armed flag", {7'b0, armed_o}, 8'd1);
        wr(2'd0, 8'h40);
        chk("R2", "disarm state", {5'b0, state_o}, 8'd0);
        rd(2'd0, d);
        chk("R2", "ctrl after disarm", d, 8'h00);
        wr(2'd0, 8'hC0);
        chk("R2", "arm wins", {7'b0, armed_o}, 8'd1);
        wr(2'd0, 8'h40);
    endtask

    task automatic t_bank();
        logic [7:0] d;
        set_sel(2'd0, 8'h05);
        set_sel(2'd1, 8'hF3);
        set_sel(2'd2, 8'h02);
        set_sel(2'd3, 8'h0F);
        rd(2'd1, d); chk("R8", "bank 11 reads zero", d, 8'h00);
        wr(2'd0, 8'h00); rd(2'd1, d); chk("R8", "bank 00", d, 8'h05);
        wr(2'd0, 8'h01); rd(2'd1, d); chk("R9", "bank 01 upper zero", d, 8'h03);
        wr(2'd0, 8'h02); rd(2'd1, d); chk("R8", "bank 10", d, 8'h02);
    endtask

    task automatic t_two_table();
        logic [7:0] d;
        go_two(4'h0); chk("R3", "S2 entry", {5'b0, state_o}, 8'd2);
        pulse(3'b001, 3'b111); chk("R3", "0000 ch0", {5'b0, state_o}, 8'd1);
        go_two(4'h0); pulse(3'b100, 3'b111); chk("R3", "0000 ch2", {5'b0, state_o}, 8'd3);
        go_two(4'h0); pulse(3'b010, 3'b111); chk("R4", "0000 ch1 unnamed", {5'b0, state_o}, 8'd2);
        go_two(4'h1); pulse(3'b010, 3'b111); chk("R3", "0001 ch1", {5'b0, state_o}, 8'd3);
        go_two(4'h2); pulse(3'b100, 3'b111); chk("R3", "0010 ch2", {5'b0, state_o}, 8'd3);
        go_two(4'h3); pulse(3'b010, 3'b111); chk("R3", "0011 ch1", {5'b0, state_o}, 8'd3);
        go_two(4'h4); pulse(3'b010, 3'b111); chk("R3", "0100 ch1", {5'b0, state_o}, 8'd1);
        go_two(4'h4); pulse(3'b100, 3'b111); chk("R3", "0100 ch2", {5'b0, state_o}, 8'd3);
        go_two(4'hD); pulse(3'b010, 3'b111); chk("R3", "1101 ch1", {5'b0, state_o}, 8'd2);
        pulse(3'b100, 3'b111); chk("R3", "1101 ch2", {5'b0, state_o}, 8'd4);
        chk("R10", "final disarms", {7'b0, armed_o}, 8'd0);
        chk("R10", "final trigger", {7'b0, trigger_o}, 8'd1);
        pulse(3'b111, 3'b111); chk("R13", "final holds", {5'b0, state_o}, 8'd4);
        rd(2'd2, d); chk("R10", "status", d, 8'h0C);
        go_two(4'h3); pulse(3'b001, 3'b111); chk("R3", "0011 ch0", {5'b0, state_o}, 8'd4);
        wr(2'd0, 8'h40); chk("R10", "trigger kept after disarm", {7'b0, trigger_o}, 8'd1);
        wr(2'd0, 8'h80); chk("R2", "arm clears trigger", {7'b0, trigger_o}, 8'd0);
    endtask

    task automatic t_reserved();
        go_two(4'hA); pulse(3'b111, 3'b111); chk("R4", "1010", {5'b0, state_o}, 8'd2);
        go_two(4'hF); pulse(3'b111, 3'b111); chk("R4", "1111", {5'b0, state_o}, 8'd2);
        go_two(4'h7); pulse(3'b111, 3'b111); chk("R4", "0111", {5'b0, state_o}, 8'd2);
    endtask

    task automatic t_priority();
        go_two(4'hD); pulse(3'b011, 3'b111); chk("R5", "1101 ch0+ch1", {5'b0, state_o}, 8'd4);
        go_two(4'h0); pulse(3'b101, 3'b111); chk("R5", "0000 ch0+ch2", {5'b0, state_o}, 8'd1);
        go_two(4'h3); pulse(3'b011, 3'b111); chk("R5", "0011 ch0+ch1", {5'b0, state_o}, 8'd4);
        go_two(4'h4); pulse(3'b110, 3'b111); chk("R5", "0100 ch1+ch2", {5'b0, state_o}, 8'd1);
        go_two(4'h1); pulse(3'b011, 3'b111); chk("R5", "0001 ch0+ch1", {5'b0, state_o}, 8'd3);
    endtask

    task automatic t_enable();
        go_two(4'h0); pulse(3'b001, 3'b110); chk("R6", "ch0 disabled", {5'b0, state_o}, 8'd2);
        pulse(3'b101, 3'b110); chk("R6", "ch2 enabled", {5'b0, state_o}, 8'd3);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        go_two(4'h2);
        wr(2'd0, 8'h01); wr(2'd1, 8'h09);
        rd(2'd1, d); chk("R7", "write while armed", d, 8'h02);
        wr(2'd0, 8'h41); wr(2'd1, 8'h09);
        rd(2'd1, d); chk("R7", "write while disarmed", d, 8'h09);
    endtask

    task automatic t_one_table();
        set_sel(2'd0, 8'h03); wr(2'd0, 8'h80); pulse(3'b010, 3'b111);
        chk("R11", "0011 ch1", {5'b0, state_o}, 8'd3);
        set_sel(2'd0, 8'h04); wr(2'd0, 8'h80); pulse(3'b001, 3'b111);
        chk("R11", "0100 ch0", {5'b0, state_o}, 8'd4);
        set_sel(2'd0, 8'h05); wr(2'd0, 8'h80); pulse(3'b110, 3'b111);
        chk("R11", "0101 ch1+ch2", {5'b0, state_o}, 8'd4);
        set_sel(2'd0, 8'h02); wr(2'd0, 8'h80); pulse(3'b100, 3'b111);
        chk("R11", "0010 ch2", {5'b0, state_o}, 8'd2);
        set_sel(2'd0, 8'h08); wr(2'd0, 8'h80); pulse(3'b111, 3'b111);
        chk("R11", "1000 reserved", {5'b0, state_o}, 8'd1);
    endtask

    task automatic t_three_table();
        go_three(4'h0); chk("R12", "S3 entry", {5'b0, state_o}, 8'd3);
        pulse(3'b001, 3'b111); chk("R12", "0000 ch0", {5'b0, state_o}, 8'd1);
        go_three(4'h1); pulse(3'b100, 3'b111); chk("R12", "0001 ch2", {5'b0, state_o}, 8'd4);
        go_three(4'h2); pulse(3'b010, 3'b111); chk("R12", "0010 ch1", {5'b0, state_o}, 8'd2);
        go_three(4'h3); pulse(3'b010, 3'b111); chk("R12", "0011 ch1 unnamed", {5'b0, state_o}, 8'd3);
        pulse(3'b001, 3'b111); chk("R12", "0011 ch0", {5'b0, state_o}, 8'd4);
    endtask

    task automatic t_disarmed();
        set_sel(2'd0, 8'h00);
        pulse(3'b111, 3'b111);
        chk("R13", "disarmed ignores matches", {5'b0, state_o}, 8'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Main sequence.
    initial begin
        rst_n = 1'b0; reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
        match_i = '0; cmp_en_i = 3'b111;
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_arm();
        t_bank();
        t_two_table();
        t_reserved();
        t_priority();
        t_enable();
        t_lock();
        t_one_table();
        t_three_table();
        t_disarmed();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule